// File: doc/BRIEF.md
# Four-Lane Integer Shader ALU

This block is the integer arithmetic stage of a shader core. Each accepted request carries an operation code, a per-lane write mask, a mode bit and three four-lane operand vectors. The block returns a four-lane result one clock later, together with a per-lane write strobe that a register file can use directly.

The operations are:
- arithmetic: add, the low and high halves of an unsigned product, and multiply-accumulate;
- shifts: logical shifts in both directions and a left rotate;
- bitwise logic: and, or, xor and complement;
- bit counting: leading-zero count and population count.

In broadcast mode only lane x of the operands takes part, and its result is offered to every lane. In vector mode each lane is computed from its own operands. Lanes whose mask bit is clear keep the value they held before. An operation code outside the supported set raises a flag and writes nothing.

Top module: `vec4_int_alu`

## Requirements
- R1: Operation codes 0x01, 0x1C, 0x1D and 0x1E give a+b (modulo 2^32), a|b, a&b and a^b.
- R2: Code 0x3C gives bits 31:0 of the unsigned product a*b. Code 0x3D gives bits 63:32 of that product. Code 0x0C gives the low 32 bits of a*b+c.
- R3: Code 0x19 shifts a left and code 0x1A shifts a right logically. Both use only bits 4:0 of b as the amount.
- R4: Code 0x1B rotates a left by b[4:0], so that an amount of zero returns a unchanged.
- R5: Code 0x18 counts the leading zeros of c and returns 32 when c is zero. Code 0x21 counts the set bits of c.
- R6: Code 0x1F returns ~c. The unary codes 0x1F, 0x18 and 0x21 ignore a and b.
- R7: With mode 0 (broadcast), every written lane receives the result computed from lane x (bits 31:0) of the operands.
- R8: With mode 1 (vector), lane i of the result is computed from lane i of a, b and c, where lane i occupies bits 32i+31:32i.
- R9: Mask bit 0 enables lane x, bit 1 lane y, bit 2 lane z and bit 3 lane w. A lane whose bit is clear keeps its previous result and has its write strobe low.
- R10: Any other code raises illegal_op for that result cycle, holds every write strobe low and leaves every lane of the result unchanged.
- R11: Results appear one clock after in_valid, with out_valid high. A cycle without in_valid gives out_valid low and no writes.
- R12: After reset the result is zero and out_valid, lane_we and illegal_op are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 6 | Operation code |
| wmask | input | 4 | Lane write mask, bit 0 = x |
| vec_mode | input | 1 | 1 = per-lane, 0 = lane-x broadcast |
| src_a | input | 128 | First operand vector |
| src_b | input | 128 | Second operand vector (shift amount) |
| src_c | input | 128 | Third operand vector (addend, unary source) |
| out_valid | output | 1 | Result cycle marker |
| result | output | 128 | Registered result vector |
| lane_we | output | 4 | Per-lane write strobes |
| illegal_op | output | 1 | Unsupported operation code seen |

## Verification
The assertions check four properties on every cycle:
- in broadcast mode, all written lanes agree;
- a lane with its strobe low did not change;
- an illegal code never comes with a write;
- strobes and the illegal flag never appear without out_valid.

The numeric result of each operation can only be shown by the bench. It sweeps all 64 operation codes over several operand sets in vector mode and compares the output with arithmetic reference values. Directed cases cover the following:
- rotate by zero;
- shift amounts above 31;
- a leading-zero count of zero;
- the top half of the full product;
- unary operations with noisy a and b;
- partial masks;
- broadcast mode.

// File: rtl/shader_alu_pkg.sv
package shader_alu_pkg;

    typedef enum logic [5:0] {
        OPC_ADD    = 6'h01,
        OPC_MADLO  = 6'h0C,
        OPC_CLZ    = 6'h18,
        OPC_SHL    = 6'h19,
        OPC_SHR    = 6'h1A,
        OPC_ROL    = 6'h1B,
        OPC_OR     = 6'h1C,
        OPC_AND    = 6'h1D,
        OPC_XOR    = 6'h1E,
        OPC_NOT    = 6'h1F,
        OPC_POPC   = 6'h21,
        OPC_MULLO  = 6'h3C,
        OPC_MULHI  = 6'h3D
    } alu_opc_e;

    typedef enum logic [3:0] {
        K_ADD, K_MUL_LO, K_MUL_HI, K_MAD_LO,
        K_SHL, K_SHR, K_ROL,
        K_OR, K_AND, K_XOR, K_NOT,
        K_CLZ, K_POPC, K_NONE
    } alu_kind_e;

endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
    import shader_alu_pkg::*;
(
    input  logic [5:0] opcode,
    output alu_kind_e  kind,
    output logic       legal
);
    always_comb begin
        legal = 1'b1;
        unique case (opcode)
            OPC_ADD:   kind = K_ADD;
            OPC_MADLO: kind = K_MAD_LO;
            OPC_CLZ:   kind = K_CLZ;
            OPC_SHL:   kind = K_SHL;
            OPC_SHR:   kind = K_SHR;
            OPC_ROL:   kind = K_ROL;
            OPC_OR:    kind = K_OR;
            OPC_AND:   kind = K_AND;
            OPC_XOR:   kind = K_XOR;
            OPC_NOT:   kind = K_NOT;
            OPC_POPC:  kind = K_POPC;
            OPC_MULLO: kind = K_MUL_LO;
            OPC_MULHI: kind = K_MUL_HI;
            default: begin
                kind  = K_NONE;
                legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/int_lane_core.sv
module int_lane_core
    import shader_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_kind_e      kind,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   c,
    output logic [W-1:0]   y
);
    localparam int SHW = $clog2(W);
    localparam int CW  = $clog2(W + 1);

    logic [SHW-1:0] amt_d;
    logic [SHW-1:0] back_amt_d;
    logic [2*W-1:0] prod_d;
    logic [CW-1:0]  lz_d;
    logic [CW-1:0]  ones_d;

    always_comb begin
        amt_d      = b[SHW-1:0];
        back_amt_d = SHW'(0) - amt_d;
        prod_d     = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        lz_d       = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (c[i]) lz_d = CW'(W - 1 - i);
        end
        ones_d = '0;
        for (int i = 0; i < W; i++) begin
            ones_d = ones_d + {{(CW-1){1'b0}}, c[i]};
        end
    end

    always_comb begin
        unique case (kind)
            K_ADD:    y = a + b;
            K_MUL_LO: y = prod_d[W-1:0];
            K_MUL_HI: y = prod_d[2*W-1:W];
            K_MAD_LO: y = prod_d[W-1:0] + c;
            K_SHL:    y = a << amt_d;
            K_SHR:    y = a >> amt_d;
            K_ROL:    y = (a << amt_d) | (a >> back_amt_d);
            K_OR:     y = a | b;
            K_AND:    y = a & b;
            K_XOR:    y = a ^ b;
            K_NOT:    y = ~c;
            K_CLZ:    y = W'(lz_d);
            K_POPC:   y = W'(ones_d);
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/vec4_int_alu.sv
module vec4_int_alu
    import shader_alu_pkg::*;
#(
    parameter int LANES = 4,
    parameter int W     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [5:0]         opcode,
    input  logic [LANES-1:0]   wmask,
    input  logic               vec_mode,
    input  logic [LANES*W-1:0] src_a,
    input  logic [LANES*W-1:0] src_b,
    input  logic [LANES*W-1:0] src_c,
    output logic               out_valid,
    output logic [LANES*W-1:0] result,
    output logic [LANES-1:0]   lane_we,
    output logic               illegal_op
);
    localparam int VW = LANES * W;

    typedef struct packed {
        logic             valid;
        logic             illegal;
        logic             bcast;
        logic [LANES-1:0] we;
        logic [VW-1:0]    res;
    } out_state_t;

    out_state_t st_d, st_q;
    alu_kind_e  kind_d;
    logic       legal_d;
    logic [W-1:0] lane_y_d [LANES];

    alu_op_decoder u_dec (
        .opcode (opcode),
        .kind   (kind_d),
        .legal  (legal_d)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        int_lane_core #(.W(W)) u_core (
            .kind (kind_d),
            .a    (src_a[g*W +: W]),
            .b    (src_b[g*W +: W]),
            .c    (src_c[g*W +: W]),
            .y    (lane_y_d[g])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.valid   = in_valid;
        st_d.illegal = in_valid & ~legal_d;
        st_d.bcast   = ~vec_mode;
        st_d.we      = '0;
        for (int i = 0; i < LANES; i++) begin
            if (in_valid && legal_d && wmask[i]) begin
                st_d.we[i]         = 1'b1;
                st_d.res[i*W +: W] = vec_mode ? lane_y_d[i] : lane_y_d[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign illegal_op = st_q.illegal;
    assign lane_we    = st_q.we;
    assign result     = st_q.res;

    // Previous result copy, used only by the hold check.
    logic [VW-1:0] prev_res_q;
    always_ff @(posedge clk) begin
        if (!rst_n) prev_res_q <= '0;
        else        prev_res_q <= st_q.res;
    end

    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (lane_we == '0));

    p_illegal_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> out_valid);

    p_we_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we != '0) |-> out_valid);

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        p_masked_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_we[g] |-> (result[g*W +: W] == prev_res_q[g*W +: W]));

        p_bcast_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.bcast && lane_we[g] && lane_we[0]) |->
                (result[g*W +: W] == result[W-1:0]));
    end
endmodule

// File: tb/tb_vec4_int_alu.sv
module tb_vec4_int_alu;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [5:0]   opcode;
    logic [3:0]   wmask;
    logic         vec_mode;
    logic [127:0] src_a, src_b, src_c;
    logic         out_valid;
    logic [127:0] result;
    logic [3:0]   lane_we;
    logic         illegal_op;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [4];

    always #2 clk = ~clk;

    vec4_int_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .wmask(wmask), .vec_mode(vec_mode), .src_a(src_a), .src_b(src_b),
        .src_c(src_c), .out_valid(out_valid), .result(result),
        .lane_we(lane_we), .illegal_op(illegal_op)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit is_legal(input logic [5:0] op);
        case (op)
            6'h01, 6'h0C, 6'h18, 6'h19, 6'h1A, 6'h1B, 6'h1C,
            6'h1D, 6'h1E, 6'h1F, 6'h21, 6'h3C, 6'h3D: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] op);
        case (op)
            6'h01, 6'h1C, 6'h1D, 6'h1E: return "R1";
            6'h0C, 6'h3C, 6'h3D:        return "R2";
            6'h19, 6'h1A:               return "R3";
            6'h1B:                      return "R4";
            6'h18, 6'h21:               return "R5";
            6'h1F:                      return "R6";
            default:                    return "R10";
        endcase
    endfunction

    function automatic logic [31:0] ref_op(input logic [5:0] op, input logic [31:0] a,
                                           input logic [31:0] b, input logic [31:0] c);
        logic [63:0] p;
        int n;
        p = 64'(a) * 64'(b);
        case (op)
            6'h01: return a + b;
            6'h0C: return p[31:0] + c;
            6'h3C: return p[31:0];
            6'h3D: return p[63:32];
            6'h19: return a << (b & 31);
            6'h1A: return a >> (b & 31);
            6'h1B: return (a << (b & 31)) | (a >> ((32 - b) & 31));
            6'h1C: return a | b;
            6'h1D: return a & b;
            6'h1E: return a ^ b;
            6'h1F: return ~c;
            6'h18: begin
                n = 0;
                while (n < 32 && c[31-n] == 1'b0) n++;
                return 32'(n);
            end
            6'h21: begin
                n = 0;
                for (int i = 0; i < 32; i++) n += int'(c[i]);
                return 32'(n);
            end
            default: return 32'h0;
        endcase
    endfunction

    task automatic issue(input logic [5:0] op, input logic [3:0] m, input logic vm,
                         input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
                         input string tag);
        bit lg;
        @(negedge clk);
        in_valid = 1'b1; opcode = op; wmask = m; vec_mode = vm;
        src_a = a; src_b = b; src_c = c;
        lg = is_legal(op);
        for (int i = 0; i < 4; i++) begin
            int s;
            s = vm ? i : 0;
            if (lg && m[i]) model[i] = ref_op(op, a[s*32 +: 32], b[s*32 +: 32], c[s*32 +: 32]);
        end
        @(posedge clk);
        #1;
        check(out_valid == 1'b1, {tag, " R11 out_valid"}, 64'(out_valid), 64'd1);
        check(illegal_op == !lg, {tag, " R10 illegal_op"}, 64'(illegal_op), 64'(!lg));
        check(lane_we == (lg ? m : 4'h0), {tag, " R9 lane_we"}, 64'(lane_we), 64'(lg ? m : 4'h0));
        for (int i = 0; i < 4; i++)
            check(result[i*32 +: 32] == model[i], {tag, " result lane"},
                  64'(result[i*32 +: 32]), 64'(model[i]));
    endtask

    task automatic idle_check;
        @(negedge clk);
        in_valid = 1'b0; opcode = 6'h01; wmask = 4'hF;
        @(posedge clk);
        #1;
        check(out_valid == 1'b0 && lane_we == 4'h0, "R11 idle no write",
              64'({out_valid, lane_we}), 64'd0);
        for (int i = 0; i < 4; i++)
            check(result[i*32 +: 32] == model[i], "R11 idle hold", 64'(result[i*32 +: 32]), 64'(model[i]));
    endtask

    function automatic logic [127:0] mk(input int seed, input logic [31:0] mul);
        logic [127:0] v;
        for (int i = 0; i < 4; i++) v[i*32 +: 32] = 32'(seed) * mul + 32'(i) * 32'h01030507 + 32'h0F0F0001;
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; opcode = '0; wmask = '0; vec_mode = 1'b0;
        src_a = '0; src_b = '0; src_c = '0;
        for (int i = 0; i < 4; i++) model[i] = 32'h0;
        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        check(result == '0 && out_valid == 1'b0 && lane_we == '0 && illegal_op == 1'b0,
              "R12 reset", 64'({out_valid, lane_we, illegal_op}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8 vector-mode sweep over every opcode and several operand sets
        for (int op = 0; op < 64; op++) begin
            for (int s = 0; s < 4; s++) begin
                issue(6'(op), 4'hF, 1'b1, mk(s + 1, 32'h9E3779B9), mk(s * 7 + 3, 32'h7F4A7C15),
                      mk(s * 13 + 5, 32'hC2B2AE35), {tag_of(6'(op)), " R8 sweep"});
            end
        end

        // R4 rotate by zero and by 32 (low bits zero)
        issue(6'h1B, 4'hF, 1'b1, {4{32'h8000_0001}}, {32'h0, 32'h20, 32'h40, 32'h1}, '0, "R4 rotate zero");
        // R3 shift amounts above 31 wrap to low five bits
        issue(6'h19, 4'hF, 1'b1, {4{32'hF000_000F}}, {32'h21, 32'h3F, 32'h20, 32'h1F}, '0, "R3 shl amount");
        issue(6'h1A, 4'hF, 1'b1, {4{32'hF000_000F}}, {32'h21, 32'h3F, 32'h20, 32'h1F}, '0, "R3 shr amount");
        // R5 leading zeros of zero and one, popcount of all ones
        issue(6'h18, 4'hF, 1'b1, '1, '1, {32'h0, 32'h1, 32'h8000_0000, 32'h0001_0000}, "R5 clz");
        issue(6'h21, 4'hF, 1'b1, '1, '1, {32'hFFFF_FFFF, 32'h0, 32'h8000_0001, 32'h1234_5678}, "R5 popcount");
        // R2 high half of the full product
        issue(6'h3D, 4'hF, 1'b1, {4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFF}}, '0, "R2 mulhi max");
        issue(6'h0C, 4'hF, 1'b1, {4{32'hFFFF_FFFF}}, {4{32'h2}}, {4{32'h5}}, "R2 madlo wrap");
        // R6 unary ops ignore a and b
        issue(6'h1F, 4'hF, 1'b1, mk(9, 32'h3), mk(11, 32'h5), {32'h0, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h1}, "R6 not");
        issue(6'h1F, 4'hF, 1'b1, '1, '0, {32'h0, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h1}, "R6 not noisy");
        // R7 broadcast mode uses lane x only
        issue(6'h01, 4'hF, 1'b0, {32'h1, 32'h2, 32'h3, 32'h100}, {32'h9, 32'h8, 32'h7, 32'h23}, '0, "R7 bcast add");
        issue(6'h1B, 4'hF, 1'b0, mk(4, 32'h11), mk(6, 32'h13), '0, "R7 bcast rol");
        // R9 partial masks keep unwritten lanes
        issue(6'h1E, 4'b0101, 1'b1, mk(21, 32'h77), mk(22, 32'h99), '0, "R9 mask 0101");
        issue(6'h1C, 4'b1000, 1'b1, mk(31, 32'h55), mk(32, 32'h33), '0, "R9 mask 1000");
        issue(6'h3C, 4'b0000, 1'b0, mk(41, 32'h5), mk(42, 32'h7), '0, "R9 mask none");
        // R10 illegal code writes nothing
        issue(6'h00, 4'hF, 1'b1, mk(51, 32'h5), mk(52, 32'h7), mk(53, 32'h9), "R10 illegal 00");
        issue(6'h3F, 4'hF, 1'b0, mk(54, 32'h5), mk(55, 32'h7), mk(56, 32'h9), "R10 illegal 3F");
        // R11 idle cycles
        idle_check();
        idle_check();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule